// File: doc/BRIEF.md
# Multiply-High Word Unit

This execution stage returns the upper half of a 32 by 32 bit product. Two 64-bit register operands arrive with an issue strobe. Only the low word of each operand takes part. A select line chooses between unsigned and signed arithmetic. The 32-bit high word of the product is written into both halves of a 64-bit result. That result appears one clock after issue, together with a valid flag.

Signed products are built in three steps. First each operand is reduced to its unsigned magnitude. Then the two magnitudes are multiplied. Finally the product is negated when the operand signs differ. A sticky summary-overflow bit travels through the stage unchanged, with the same one-cycle delay. The issuing logic must mark every issued operation as a word-sized operation.

Top module: `mulhw_unit`

## Requirements
- R1: Operand bits 63:32 of `op_a` and `op_b` have no effect on `res_data`.
- R2: When `sgn_sel` is 0 at issue, `res_data[31:0]` equals bits 63:32 of the unsigned 64-bit product of `op_a[31:0]` and `op_b[31:0]`.
- R3: Whenever `res_vld` is 1, `res_data[63:32]` equals `res_data[31:0]`.
- R4: When `sgn_sel` is 1 at issue, `res_data[31:0]` equals bits 63:32 of the two's-complement product of `op_a[31:0]` and `op_b[31:0]`. This includes the operand value 0x80000000, whose magnitude is 2^31.
- R5: On every cycle after reset, `so_out` equals the `so_in` value that was sampled at the previous rising clock edge.
- R6: `res_vld` is 1 exactly in the cycle after a cycle in which `iss_vld` and `word_op` are both 1.
- R7: While `rst_n` is low, `res_vld`, `res_data` and `so_out` are all 0.
- R8: Whenever `iss_vld` is 1, `word_op` is also 1 (this is a contract on the issuing logic).
- R9: In a cycle after no issue, `res_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_vld | input | 1 | Issue strobe |
| word_op | input | 1 | Marks the operation as word-sized |
| sgn_sel | input | 1 | 1 selects signed arithmetic, 0 selects unsigned |
| op_a | input | 64 | First operand; only bits 31:0 are used |
| op_b | input | 64 | Second operand; only bits 31:0 are used |
| so_in | input | 1 | Summary-overflow bit in |
| res_vld | output | 1 | Result valid, one cycle after issue |
| res_data | output | 64 | High product word, written into both halves |
| so_out | output | 1 | Summary-overflow bit, delayed by one cycle |

## Verification
The checker assumes that the issuing logic never raises `iss_vld` without also raising `word_op`. It flags any breach of this contract under R8. The stimulus holds `word_op` high on every issue cycle and also on every idle cycle, so the contract is never broken. The arithmetic properties look back one cycle to the issued operands. They therefore rely on the operands being stable across the clock edge. To keep them stable, the bench changes inputs only on falling edges. Upper operand bits are always random, so any leak of those bits into the arithmetic would show up in the result.

// File: rtl/mulhw_pkg.sv
package mulhw_pkg;
    localparam int XLEN = 64;
    localparam int WLEN = XLEN / 2;

    typedef struct packed {
        logic            vld;
        logic            so;
        logic [XLEN-1:0] data;
    } mulhw_stage_t;
endpackage

// File: rtl/mulhw_mag.sv
module mulhw_mag #(
    parameter int W = 32
) (
    input  logic [W-1:0] val,
    input  logic         use_sign,
    output logic [W-1:0] mag,
    output logic         neg
);
    // A W-bit unsigned magnitude holds 2^(W-1) for the most negative input
    always_comb begin
        neg = use_sign & val[W-1];
        mag = neg ? (~val + {{(W-1){1'b0}}, 1'b1}) : val;
    end
endmodule

// File: rtl/mulhw_core.sv
module mulhw_core #(
    parameter int W = 32
) (
    input  logic [W-1:0] mag_a,
    input  logic [W-1:0] mag_b,
    input  logic         flip,
    output logic [W-1:0] hi
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod;
    logic [PW-1:0] fixed;

    always_comb begin
        prod  = {{W{1'b0}}, mag_a} * {{W{1'b0}}, mag_b};
        fixed = flip ? (~prod + {{(PW-1){1'b0}}, 1'b1}) : prod;
        hi    = fixed[PW-1:W];
    end
endmodule

// File: rtl/mulhw_unit.sv
module mulhw_unit
    import mulhw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iss_vld,
    input  logic            word_op,
    input  logic            sgn_sel,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic            so_in,
    output logic            res_vld,
    output logic [XLEN-1:0] res_data,
    output logic            so_out
);
    localparam int NOPS  = 2;
    localparam int LANES = XLEN / WLEN;

    logic [WLEN-1:0] low_w [NOPS];
    logic [WLEN-1:0] mag_w [NOPS];
    logic [NOPS-1:0] neg_w;
    logic [WLEN-1:0] hi_w;
    logic [XLEN-1:0] rep_w;

    mulhw_stage_t st_d, st_q;

    assign low_w[0] = op_a[WLEN-1:0];
    assign low_w[1] = op_b[WLEN-1:0];

    for (genvar g = 0; g < NOPS; g++) begin : g_mag
        mulhw_mag #(.W(WLEN)) u_mag (
            .val      (low_w[g]),
            .use_sign (sgn_sel),
            .mag      (mag_w[g]),
            .neg      (neg_w[g])
        );
    end

    mulhw_core #(.W(WLEN)) u_core (
        .mag_a (mag_w[0]),
        .mag_b (mag_w[1]),
        .flip  (^neg_w),
        .hi    (hi_w)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_rep
        assign rep_w[l*WLEN +: WLEN] = hi_w;
    end

    always_comb begin
        st_d     = st_q;
        st_d.so  = so_in;
        st_d.vld = iss_vld & word_op;
        if (iss_vld & word_op) begin
            st_d.data = rep_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_vld  = st_q.vld;
    assign res_data = st_q.data;
    assign so_out   = st_q.so;
endmodule

// File: rtl/mulhw_chk.sv
module mulhw_chk
    import mulhw_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            iss_vld,
    input logic            word_op,
    input logic            sgn_sel,
    input logic [XLEN-1:0] op_a,
    input logic [XLEN-1:0] op_b,
    input logic            so_in,
    input logic            res_vld,
    input logic [XLEN-1:0] res_data,
    input logic            so_out
);
    function automatic logic [WLEN-1:0] ref_u(logic [XLEN-1:0] a, logic [XLEN-1:0] b);
        logic [XLEN-1:0] p;
        p = {{WLEN{1'b0}}, a[WLEN-1:0]} * {{WLEN{1'b0}}, b[WLEN-1:0]};
        return p[XLEN-1:WLEN];
    endfunction

    function automatic logic [WLEN-1:0] ref_s(logic [XLEN-1:0] a, logic [XLEN-1:0] b);
        logic signed [XLEN-1:0] p;
        p = $signed({{WLEN{a[WLEN-1]}}, a[WLEN-1:0]}) * $signed({{WLEN{b[WLEN-1]}}, b[WLEN-1:0]});
        return p[XLEN-1:WLEN];
    endfunction

    // R2
    unsigned_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && word_op && !sgn_sel) |=> res_data[WLEN-1:0] == ref_u($past(op_a), $past(op_b)));

    // R4
    signed_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && word_op && sgn_sel) |=> res_data[WLEN-1:0] == ref_s($past(op_a), $past(op_b)));

    // R3
    replicate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> res_data[XLEN-1:WLEN] == res_data[WLEN-1:0]);

    // R5
    so_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> so_out == $past(so_in));

    // R6
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && word_op) |=> res_vld);

    // R6
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(iss_vld && word_op) |=> !res_vld);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(iss_vld && word_op) |=> $stable(res_data));

    // R8
    word_contract_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> word_op);
endmodule

bind mulhw_unit mulhw_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .iss_vld  (iss_vld),
    .word_op  (word_op),
    .sgn_sel  (sgn_sel),
    .op_a     (op_a),
    .op_b     (op_b),
    .so_in    (so_in),
    .res_vld  (res_vld),
    .res_data (res_data),
    .so_out   (so_out)
);

// File: tb/sim_mulhw_unit.sv
module sim_mulhw_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_vld = 1'b0;
    logic        word_op = 1'b1;
    logic        sgn_sel = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        so_in = 1'b0;
    logic        res_vld;
    logic [63:0] res_data;
    logic        so_out;

    int n_chk = 0;
    int n_bad = 0;

    logic        e_vld = 1'b0;
    logic [63:0] e_data = '0;
    logic        e_so = 1'b0;
    string       e_tag = "R2";

    always #5 clk = ~clk;

    mulhw_unit u0 (
        .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .word_op(word_op),
        .sgn_sel(sgn_sel), .op_a(op_a), .op_b(op_b), .so_in(so_in),
        .res_vld(res_vld), .res_data(res_data), .so_out(so_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_hi(input bit s, input logic [63:0] a, input logic [63:0] b);
        longint unsigned pu;
        longint          ps;
        if (s) begin
            ps = longint'($signed(a[31:0])) * longint'($signed(b[31:0]));
            return ps[63:32];
        end
        pu = longint'({32'h0, a[31:0]}) * longint'({32'h0, b[31:0]});
        return pu[63:32];
    endfunction

    // compare outputs against the model, then drive the next inputs
    task automatic step(input bit v, input bit s, input logic [63:0] a, input logic [63:0] b, input string tag);
        @(negedge clk);
        chk(res_vld == e_vld, "R6", {63'h0, res_vld}, {63'h0, e_vld});
        chk(so_out == e_so, "R5", {63'h0, so_out}, {63'h0, e_so});
        chk(res_data == e_data, e_tag, res_data, e_data);
        if (res_vld) chk(res_data[63:32] == res_data[31:0], "R3", res_data, {res_data[31:0], res_data[31:0]});
        iss_vld = v; sgn_sel = s; op_a = a; op_b = b;
        so_in = $urandom_range(0, 1);
        e_vld = v;
        e_so  = so_in;
        if (v) begin
            e_data = {2{model_hi(s, a, b)}};
            e_tag  = tag;
        end else begin
            e_tag = "R9";
        end
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] corner [5];
        logic [63:0] ta;
        logic [63:0] tb;
        logic [31:0] r1_first;
        corner[0] = 32'h0; corner[1] = 32'h1; corner[2] = 32'hFFFF_FFFF;
        corner[3] = 32'h7FFF_FFFF; corner[4] = 32'h8000_0000;
        so_in = 1'b1;
        #12;
        // R7 reset state
        chk(res_vld == 1'b0, "R7", {63'h0, res_vld}, 64'h0);
        chk(res_data == 64'h0, "R7", res_data, 64'h0);
        chk(so_out == 1'b0, "R7", {63'h0, so_out}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        so_in = 1'b0;
        e_so = 1'b0;
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    step(1'b1, s[0], {$urandom(), corner[i]}, {$urandom(), corner[j]}, s ? "R4" : "R2");
        for (int k = 0; k < 200; k++) begin
            bit v;
            v = ($urandom_range(0, 3) != 0);
            step(v, $urandom_range(0, 1), {$urandom(), $urandom()}, {$urandom(), $urandom()},
                 sgn_sel ? "R4" : "R2");
        end
        // R9 hold across idle cycles
        step(1'b1, 1'b1, {32'h0, 32'h8000_0000}, {32'h0, 32'h8000_0000}, "R4");
        step(1'b0, 1'b0, 64'h0, 64'h0, "R9");
        step(1'b0, 1'b1, '1, '1, "R9");
        // R1 upper bits must not change the result
        ta = {32'h1234_5678, 32'hDEAD_BEEF};
        tb = {32'h0, 32'h9ABC_DEF0};
        step(1'b1, 1'b1, ta, tb, "R1");
        step(1'b0, 1'b0, 64'h0, 64'h0, "R9");
        r1_first = res_data[31:0];
        step(1'b1, 1'b1, {32'hFFFF_FFFF, ta[31:0]}, {32'h5555_AAAA, tb[31:0]}, "R1");
        step(1'b0, 1'b0, 64'h0, 64'h0, "R9");
        chk(res_data[31:0] == r1_first, "R1", res_data, {32'h0, r1_first});
        step(1'b0, 1'b0, 64'h0, 64'h0, "R9");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule